// File: doc/BRIEF.md
# Watchdog Countdown Timer

This block is a memory-mapped watchdog. A 32-bit counter counts down toward zero while the watchdog is enabled. Software keeps the system alive by writing a fixed 16-bit key to the restart register, which copies the programmed reload value back into the counter. If software stops doing so, the count runs out. The block then raises a one-cycle timeout event. That event is routed to a reset request, an interrupt, an external trigger and a boot-swap request, and each of these routes has its own enable bit. The reset request carries a scope code that tells downstream logic whether to reset the whole chip, the SoC domain or only the CPU.

The counter can step on every clock cycle or only on an external 1 MHz enable strobe, and a control bit chooses between the two. When the count expires the counter stops at zero. It stays there until the next valid restart, so one expiry yields exactly one event. Clock generation, pulse shaping of the external signal and the boot-source swap are handled by the surrounding logic.

Top module: `wdog_timer`

## Requirements
- R1: After synchronous reset, the control register reads 0, the reload register and the live count both read RELOAD_INIT (default 1000), and every event output is low.
- R2: Byte offset 0x00 reads the live count and offset 0x04 reads back the last value written to the reload register. Offset 0x0C holds the 8 control bits in data bits 7:0, and data bits 31:8 of that register always read 0. Offset 0x08 always reads 0. Any other address reads 0 and ignores writes.
- R3: A write of exactly 0x00004755 to offset 0x08 loads the reload value into the counter on that clock edge. A write of any other value to that offset leaves the count unchanged.
- R4: Control bit 0 enables counting. Control bit 4 selects the step source: when it is 0 the counter steps on every clock cycle, and when it is 1 the counter steps only on cycles where us_tick is high. The count drops by exactly one per step.
- R5: While control bit 0 is clear, the count holds its value.
- R6: A step that takes the count from 1 to 0, or a step taken while the count is already 0, drives timeout_evt high for exactly one cycle. After that the count stays at 0 and no further event occurs, even if control is rewritten, until a valid restart.
- R7: During the event cycle, rst_req follows control bit 1, irq follows bit 2, ext_trig follows bit 3 and boot_swap follows bit 7. Outside the event cycle all four are low.
- R8: Control bits 6:5 select the reset scope. rst_scope reads 1 for field 01 (full chip), 2 for field 10 or 11 (CPU only) and 0 for field 00 (SoC). rst_scope is 0 whenever rst_req is low.
- R9: A valid restart wins over a step in the same cycle, so the counter holds exactly the reload value after that edge. A restart after an expiry resumes the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | 1 MHz step strobe, one cycle wide |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| timeout_evt | output | 1 | One-cycle expiry event |
| rst_req | output | 1 | Reset request, gated by control bit 1 |
| rst_scope | output | 2 | Reset scope: 0 SoC, 1 full chip, 2 CPU |
| irq | output | 1 | Interrupt pulse, gated by control bit 2 |
| ext_trig | output | 1 | External-signal trigger, gated by control bit 3 |
| boot_swap | output | 1 | Secondary-boot request, gated by control bit 7 |

## Verification
A corrupted count shows up on the very next read of offset 0x00. It also shifts the event cycle, and the bench samples that cycle exactly, so a count that is off by one step misses by one cycle. If the expiry flag is wrong, the counter either fires again while it should sit at zero, or freezes after a restart; the bench catches this within a few cycles of the expiry. If the control bits are decoded wrongly, the wrong output or the wrong scope code appears in the single event cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [15:0] RESTART_KEY = 16'h4755;

    localparam logic [3:0] OFF_COUNT   = 4'h0;
    localparam logic [3:0] OFF_RELOAD  = 4'h4;
    localparam logic [3:0] OFF_RESTART = 4'h8;
    localparam logic [3:0] OFF_CTRL    = 4'hC;

    typedef enum logic [1:0] {
        SCOPE_SOC  = 2'd0,
        SCOPE_FULL = 2'd1,
        SCOPE_CPU  = 2'd2
    } scope_e;

    // bit 7 .. bit 0
    typedef struct packed {
        logic       boot_swap;
        logic [1:0] scope;
        logic       tick_sel;
        logic       ext_en;
        logic       irq_en;
        logic       rst_en;
        logic       run;
    } ctrl_t;

    function automatic scope_e map_scope(input logic [1:0] field);
        case (field)
            2'b00:   return SCOPE_SOC;
            2'b01:   return SCOPE_FULL;
            default: return SCOPE_CPU;
        endcase
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int             DW          = 32,
    parameter int             ADDR_W      = 4,
    parameter logic [DW-1:0]  RELOAD_INIT = DW'(1000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     count,
    output logic [DW-1:0]     bus_rdata,
    output ctrl_t             ctrl,
    output logic [DW-1:0]     reload,
    output logic              restart
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic sel_count, sel_reload, sel_restart, sel_ctrl;

    assign sel_count   = (bus_addr == ADDR_W'(OFF_COUNT));
    assign sel_reload  = (bus_addr == ADDR_W'(OFF_RELOAD));
    assign sel_restart = (bus_addr == ADDR_W'(OFF_RESTART));
    assign sel_ctrl    = (bus_addr == ADDR_W'(OFF_CTRL));

    assign restart = bus_wr && sel_restart && (bus_wdata == DW'(RESTART_KEY));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= RELOAD_INIT;
        end else if (bus_wr) begin
            if (sel_ctrl)   ctrl   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (sel_reload) reload <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_count)       bus_rdata = count;
        else if (sel_reload) bus_rdata = reload;
        else if (sel_ctrl)   bus_rdata = DW'(ctrl);
    end

    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && sel_ctrl) |=> $stable(ctrl));

    assert_reload_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && sel_reload) |=> $stable(reload));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int             DW          = 32,
    parameter logic [DW-1:0]  RELOAD_INIT = DW'(1000)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick_sel,
    input  logic          us_tick,
    input  logic          restart,
    input  logic [DW-1:0] reload,
    output logic [DW-1:0] count,
    output logic          evt
);
    logic expired;
    logic step;

    assign step = tick_sel ? us_tick : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= RELOAD_INIT;
            expired <= 1'b0;
            evt     <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (restart) begin
                count   <= reload;
                expired <= 1'b0;
            end else if (run && !expired && step) begin
                if (count <= DW'(1)) begin
                    count   <= '0;
                    expired <= 1'b1;
                    evt     <= 1'b1;
                end else begin
                    count <= count - DW'(1);
                end
            end
        end
    end

    assert_evt_single_R6: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);

    assert_expired_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (expired && !restart) |=> (count == '0) && !evt);

    assert_stopped_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(count));

    assert_restart_load_R3: assert property (@(posedge clk) disable iff (rst)
        restart |=> (count == $past(reload)) && !evt);

    assert_step_dec_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !expired && step && !restart && count > DW'(1))
        |=> count == $past(count) - DW'(1));

endmodule

// File: rtl/wdog_event.sv
module wdog_event
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt,
    input  logic       rst_en,
    input  logic       irq_en,
    input  logic       ext_en,
    input  logic       swap_en,
    input  logic [1:0] scope_field,
    output logic       rst_req,
    output logic [1:0] rst_scope,
    output logic       irq,
    output logic       ext_trig,
    output logic       boot_swap
);
    scope_e scope_sel;

    assign scope_sel = map_scope(scope_field);

    assign rst_req   = evt && rst_en;
    assign irq       = evt && irq_en;
    assign ext_trig  = evt && ext_en;
    assign boot_swap = evt && swap_en;
    assign rst_scope = rst_req ? scope_sel : SCOPE_SOC;

    assert_outputs_need_evt_R7: assert property (@(posedge clk) disable iff (rst)
        (rst_req || irq || ext_trig || boot_swap) |-> evt);

    assert_scope_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !rst_req |-> rst_scope == 2'd0);

    assert_scope_legal_R8: assert property (@(posedge clk) disable iff (rst)
        rst_scope != 2'd3);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int             DW          = 32,
    parameter int             ADDR_W      = 4,
    parameter logic [DW-1:0]  RELOAD_INIT = DW'(1000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              timeout_evt,
    output logic              rst_req,
    output logic [1:0]        rst_scope,
    output logic              irq,
    output logic              ext_trig,
    output logic              boot_swap
);
    ctrl_t         ctrl;
    logic [DW-1:0] reload;
    logic [DW-1:0] count;
    logic          restart;

    wdog_regs #(
        .DW(DW), .ADDR_W(ADDR_W), .RELOAD_INIT(RELOAD_INIT)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .count(count), .bus_rdata(bus_rdata),
        .ctrl(ctrl), .reload(reload), .restart(restart)
    );

    wdog_counter #(
        .DW(DW), .RELOAD_INIT(RELOAD_INIT)
    ) u_cnt (
        .clk(clk), .rst(rst),
        .run(ctrl.run), .tick_sel(ctrl.tick_sel), .us_tick(us_tick),
        .restart(restart), .reload(reload),
        .count(count), .evt(timeout_evt)
    );

    wdog_event u_evt (
        .clk(clk), .rst(rst),
        .evt(timeout_evt),
        .rst_en(ctrl.rst_en), .irq_en(ctrl.irq_en),
        .ext_en(ctrl.ext_en), .swap_en(ctrl.boot_swap),
        .scope_field(ctrl.scope),
        .rst_req(rst_req), .rst_scope(rst_scope),
        .irq(irq), .ext_trig(ext_trig), .boot_swap(boot_swap)
    );

endmodule

// File: tb/sim_wdog_timer.sv
`timescale 1ns/1ps
module sim_wdog_timer;

    localparam logic [31:0] INIT = 32'd1000;
    localparam logic [31:0] KEY  = 32'h0000_4755;

    logic        clk = 1'b0;
    logic        rst;
    logic        us_tick;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        timeout_evt, rst_req, irq, ext_trig, boot_swap;
    logic [1:0]  rst_scope;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    wdog_timer u0 (
        .clk(clk), .rst(rst), .us_tick(us_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .timeout_evt(timeout_evt),
        .rst_req(rst_req), .rst_scope(rst_scope), .irq(irq),
        .ext_trig(ext_trig), .boot_swap(boot_swap)
    );

    function automatic logic [1:0] exp_scope(input logic [1:0] f);
        if (f == 2'b00) return 2'd0;
        if (f == 2'b01) return 2'd1;
        return 2'd2;
    endfunction

    function automatic logic [5:0] exp_outs(input logic ev, input logic [7:0] c);
        logic rq;
        rq = ev & c[1];
        return {ev, rq, ev & c[2], ev & c[3], ev & c[7], 1'b0} |
               {4'b0, (rq ? exp_scope(c[6:5]) : 2'd0)} ;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [5:0] act_outs();
        return {timeout_evt, rst_req, irq, ext_trig, boot_swap, 1'b0} |
               {4'b0, rst_scope};
    endfunction

    // stop, load N, restart, enable with control bits c (fast step), watch expiry
    task automatic run_timeout(input logic [31:0] n, input logic [7:0] c_in);
        logic [31:0] v;
        logic [7:0]  c;
        int k;
        c = (c_in & 8'hEE) | 8'h01;
        wr(4'hC, 32'h0);
        wr(4'h4, n);
        wr(4'h8, KEY);
        rd(4'h0, v); chk("R3 restart load", v, n);
        wr(4'hC, {24'h0, c});
        k = (n == 0) ? 1 : int'(n);
        repeat (k - 1) @(negedge clk);
        rd(4'h0, v); chk("R4 count before expiry", v, (n == 0) ? 32'd0 : 32'd1);
        chk("R7 outputs idle before expiry", {26'h0, act_outs()}, {26'h0, exp_outs(1'b0, c)});
        @(negedge clk);
        rd(4'h0, v); chk("R6 count at expiry", v, 32'd0);
        chk("R7 R8 outputs at expiry", {26'h0, act_outs()}, {26'h0, exp_outs(1'b1, c)});
        @(negedge clk);
        chk("R6 single cycle event", {31'h0, timeout_evt}, 32'd0);
        wr(4'hC, {24'h0, c});
        @(negedge clk);
        rd(4'h0, v); chk("R6 stays stopped after rewrite", v, 32'd0);
        chk("R6 no second event", {31'h0, timeout_evt}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        rst = 1'b1; us_tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1
        rd(4'hC, v); chk("R1 ctrl reset", v, 32'h0);
        rd(4'h4, v); chk("R1 reload reset", v, INIT);
        rd(4'h0, v); chk("R1 count reset", v, INIT);
        chk("R1 outputs reset", {26'h0, act_outs()}, 32'h0);

        // R2
        wr(4'h4, 32'h1234_5678);
        rd(4'h4, v); chk("R2 reload readback", v, 32'h1234_5678);
        wr(4'hC, 32'hFFFF_FF00);
        rd(4'hC, v); chk("R2 ctrl upper bits", v, 32'h0);
        wr(4'hC, 32'h0000_00EE);
        rd(4'hC, v); chk("R2 ctrl readback", v, 32'hEE);
        wr(4'hC, 32'h0);
        rd(4'h8, v); chk("R2 restart reads zero", v, 32'h0);
        wr(4'h2, 32'hDEAD_BEEF);
        rd(4'h2, v); chk("R2 unmapped reads zero", v, 32'h0);
        rd(4'h4, v); chk("R2 unmapped write ignored", v, 32'h1234_5678);

        // R3
        wr(4'h8, 32'h0000_1234);
        rd(4'h0, v); chk("R3 wrong key ignored", v, INIT);
        wr(4'h8, 32'h0001_4755);
        rd(4'h0, v); chk("R3 key upper bits must be zero", v, INIT);
        wr(4'h8, KEY);
        rd(4'h0, v); chk("R3 key loads count", v, 32'h1234_5678);

        // R4 fast step, R5 stop
        wr(4'h4, 32'd20);
        wr(4'h8, KEY);
        wr(4'hC, 32'h01);
        rd(4'h0, v); chk("R4 no step on enable edge", v, 32'd20);
        repeat (5) @(negedge clk);
        rd(4'h0, v); chk("R4 fast step count", v, 32'd15);
        wr(4'hC, 32'h00);
        rd(4'h0, v); chk("R5 last step on disable edge", v, 32'd14);
        repeat (10) @(negedge clk);
        rd(4'h0, v); chk("R5 count holds when stopped", v, 32'd14);

        // R4 slow step
        wr(4'hC, 32'h11);
        repeat (5) @(negedge clk);
        rd(4'h0, v); chk("R4 no step without tick", v, 32'd14);
        for (int i = 0; i < 3; i++) begin
            us_tick = 1'b1; @(negedge clk); us_tick = 1'b0;
            @(negedge clk);
        end
        rd(4'h0, v); chk("R4 one step per tick", v, 32'd11);

        // R9 restart priority
        wr(4'hC, 32'h00);
        wr(4'h4, 32'd50);
        wr(4'h8, KEY);
        wr(4'hC, 32'h01);
        repeat (3) @(negedge clk);
        rd(4'h0, v); chk("R9 running before restart", v, 32'd47);
        wr(4'h8, KEY);
        rd(4'h0, v); chk("R9 restart wins over step", v, 32'd50);
        @(negedge clk);
        rd(4'h0, v); chk("R9 resumes after restart", v, 32'd49);

        // R6 R7 R8 directed corners
        run_timeout(32'd0, 8'h0E);
        run_timeout(32'd1, 8'hAE);
        run_timeout(32'd5, 8'h42);
        run_timeout(32'd3, 8'h62);
        run_timeout(32'd2, 8'h00);

        // R9 restart after expiry
        wr(4'h8, KEY);
        rd(4'h0, v); chk("R9 reload after expiry", v, 32'd2);
        @(negedge clk);
        rd(4'h0, v); chk("R9 counting after expiry", v, 32'd1);

        // random
        for (int i = 0; i < 24; i++) begin
            run_timeout(32'($urandom_range(1, 40)), 8'($urandom));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule